// File: doc/BRIEF.md
# Paged program-memory table reader

This block carries out table-read operations against a 2048-word, 14-bit program memory. A CPU core loads an 8-bit table pointer through a small register port, then pulses a start strobe together with a page-mode select, its current program counter and the data-memory address that will receive the result. The block composes an 11-bit table address. That address has the pointer as its low byte. Its top three bits come either from the page of the program counter or are forced to all ones, which reaches the last 256-word page.

The fetched word is split in two. The low byte goes out through a single-cycle data-memory write. The upper six bits are captured in a high-byte register that the CPU can read but never write. Its two top bits always read as zero. Every operation occupies exactly two cycles: one for the synchronous memory fetch and one for the write-back. A busy flag and a one-cycle done pulse frame the operation. Each new read replaces whatever the high register held before.

Top module: `tblrd_top`

## Requirements
- R1: While reset is active, and after its release, ptr_rdata, hi_rdata, busy, done, pm_en and dm_we are all 0.
- R2: A cycle with ptr_we=1 loads ptr_wdata into the pointer, which appears on ptr_rdata in the next cycle; with ptr_we=0 ptr_rdata holds. A start in the same cycle as a pointer write uses the old pointer.
- R3: With mode=0 (current page), the fetch address is {pc[10:8], pointer}. Both pc and the pointer are sampled in the cycle the start is accepted.
- R4: With mode=1 (last page), the fetch address is {3'b111, pointer}, which lies in 0x700 to 0x7FF whatever pc holds.
- R5: In the done cycle, dm_we=1, dm_wdata equals bits 7:0 of the fetched word and dm_addr equals dst_addr sampled at acceptance; dm_we is 0 in every other cycle.
- R6: After the done cycle, hi_rdata[5:0] equals bits 13:8 of the fetched word and hi_rdata[7:6] reads 0.
- R7: When start=1 and busy=0 at a clock edge, the next cycle has pm_en=1 and busy=1 with pm_addr driven. The cycle after has done=1 and busy=1 with pm_rdata consumed. The cycle after that has done=0 and busy=0. So the operation takes two cycles.
- R8: A start that is high while busy=1 is ignored: it neither extends nor restarts the operation.
- R9: hi_rdata holds its value except in the cycle after done, so a later read replaces the value left by an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ptr_we | input | 1 | Table pointer write enable |
| ptr_wdata | input | 8 | Table pointer write data |
| ptr_rdata | output | 8 | Table pointer read-back |
| hi_rdata | output | 8 | Read-only high-byte register (top two bits zero) |
| start | input | 1 | Begin a table read (taken only when idle) |
| mode | input | 1 | 0: page from pc, 1: last page |
| pc | input | 11 | Current program counter |
| dst_addr | input | 8 | Data-memory destination for the low byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse in the write-back cycle |
| pm_en | output | 1 | Program-memory read enable |
| pm_addr | output | 11 | Program-memory read address |
| pm_rdata | input | 14 | Program-memory data, valid the cycle after pm_en |
| dm_we | output | 1 | Data-memory write enable |
| dm_addr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (low byte of word) |

## Verification
The hardest situation to reach from the ports is a start strobe that lands during the write-back cycle, when the sequencer is about to go idle. An off-by-one acceptance there would silently chain a second read. The stimulus holds start high across both busy cycles, with mode and pc changed, in a random subset of operations, and then checks that busy drops. Random pointers, pages and destinations are mixed with directed extremes: pointer 0x00 and 0xFF, pc at the top and bottom pages, and words with the upper bits set. This covers the address composition and the high-register overwrite.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2
  } tbl_state_e;

  typedef enum logic {
    PG_CURRENT = 1'b0,
    PG_LAST    = 1'b1
  } page_sel_e;
endpackage

// File: rtl/tblrd_ptr_reg.sv
module tblrd_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] q
);
  logic [PTR_W-1:0] ptr_d, ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (we) ptr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign q = ptr_q;

  // R2: pointer holds unless written
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R2: a write lands next cycle
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
  import tblrd_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int PTR_W = 8
) (
  input  page_sel_e        sel,
  input  logic [PC_W-1:0]  pc,
  input  logic [PTR_W-1:0] ptr,
  output logic [PC_W-1:0]  addr
);
  localparam int PAGE_W = PC_W - PTR_W;

  logic [PAGE_W-1:0] page;

  always_comb begin
    if (sel == PG_LAST) page = '1;
    else                page = pc[PC_W-1:PTR_W];
    addr = {page, ptr};
  end
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DM_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PC_W-1:0]  addr_in,
  input  logic [DM_AW-1:0] dst_in,
  output logic             busy,
  output logic             done,
  output logic             pm_en,
  output logic [PC_W-1:0]  pm_addr,
  output logic             dm_we,
  output logic [DM_AW-1:0] dm_addr
);
  tbl_state_e       state_d, state_q;
  logic             accept;
  logic [PC_W-1:0]  addr_q;
  logic [DM_AW-1:0] dst_q;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dst_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_in;
      dst_q  <= dst_in;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign pm_en   = (state_q == ST_FETCH);
  assign done    = (state_q == ST_LOAD);
  assign dm_we   = (state_q == ST_LOAD);
  assign pm_addr = addr_q;
  assign dm_addr = dst_q;

  // R7: accepted start leads to a fetch cycle
  p_accept_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (pm_en && busy && !done));
  // R7: fetch is followed by write-back
  p_fetch_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_en |=> (done && !pm_en));
  // R7: done is a single pulse, then idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R8: start during write-back does not restart
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> !busy);
  // R3: fetch address is the one presented at acceptance
  p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_en |-> (pm_addr == $past(addr_in)));
  // R5: destination captured at acceptance
  p_dst_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> (dm_addr == $past(dst_in, 2)));
endmodule

// File: rtl/tblrd_hi_reg.sv
module tblrd_hi_reg #(
  parameter int HI_W   = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HI_W-1:0]   word_hi,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - HI_W;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_q <= '0;
    else if (load) hi_q <= word_hi;
  end

  assign rdata = {{PAD_W{1'b0}}, hi_q};

  // R6: captured upper bits appear after the load cycle
  p_hi_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rdata[HI_W-1:0] == $past(word_hi)));
  // R9: no change without a load
  p_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rdata));
endmodule

// File: rtl/tblrd_top.sv
module tblrd_top
  import tblrd_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 14,
  parameter int DATA_W = 8,
  parameter int DM_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [PTR_W-1:0]  ptr_rdata,
  output logic [DATA_W-1:0] hi_rdata,
  input  logic              start,
  input  logic              mode,
  input  logic [PC_W-1:0]   pc,
  input  logic [DM_AW-1:0]  dst_addr,
  output logic              busy,
  output logic              done,
  output logic              pm_en,
  output logic [PC_W-1:0]   pm_addr,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic              dm_we,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [DATA_W-1:0] dm_wdata
);
  localparam int HI_W   = WORD_W - DATA_W;
  localparam int PAGE_W = PC_W - PTR_W;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [PC_W-1:0] tbl_addr;
  page_sel_e       sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel = page_sel_e'(mode);

  tblrd_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_int_n), .we(ptr_we), .wdata(ptr_wdata), .q(ptr_rdata)
  );

  tblrd_addr_gen #(.PC_W(PC_W), .PTR_W(PTR_W)) u_addr (
    .sel(sel), .pc(pc), .ptr(ptr_rdata), .addr(tbl_addr)
  );

  tblrd_ctrl #(.PC_W(PC_W), .DM_AW(DM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .addr_in(tbl_addr),
    .dst_in(dst_addr), .busy(busy), .done(done), .pm_en(pm_en),
    .pm_addr(pm_addr), .dm_we(dm_we), .dm_addr(dm_addr)
  );

  tblrd_hi_reg #(.HI_W(HI_W), .DATA_W(DATA_W)) u_hi (
    .clk(clk), .rst_n(rst_int_n), .load(done),
    .word_hi(pm_rdata[WORD_W-1:DATA_W]), .rdata(hi_rdata)
  );

  assign dm_wdata = pm_rdata[DATA_W-1:0];

  // R4: last-page mode always reaches the top page
  p_last_page_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && mode) |=> (pm_addr[PC_W-1:PTR_W] == {PAGE_W{1'b1}}));
  // R5: write data is the low byte of the memory word
  p_dm_data_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    dm_we |-> (dm_wdata == pm_rdata[DATA_W-1:0]));
  // R1: quiet outputs while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!busy && !dm_we && !pm_en));
endmodule

// File: tb/tb_tblrd_top.sv
module tb_tblrd_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_we;
  logic [7:0]  ptr_wdata;
  logic [7:0]  ptr_rdata;
  logic [7:0]  hi_rdata;
  logic        start;
  logic        mode;
  logic [10:0] pc;
  logic [7:0]  dst_addr;
  logic        busy, done, pm_en, dm_we;
  logic [10:0] pm_addr;
  logic [13:0] pm_rdata;
  logic [7:0]  dm_addr, dm_wdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] cur_ptr;
  logic [7:0] last_hi;

  always #4 clk = ~clk;

  tblrd_top dut (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_rdata(ptr_rdata), .hi_rdata(hi_rdata), .start(start), .mode(mode),
    .pc(pc), .dst_addr(dst_addr), .busy(busy), .done(done), .pm_en(pm_en),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata)
  );

  function automatic logic [13:0] mem_word(logic [10:0] a);
    logic [13:0] x;
    x = 14'({3'b000, a} * 14'd397);
    return x ^ 14'h2A5B ^ {a[2:0], 11'd0};
  endfunction

  // synchronous program memory model
  always_ff @(posedge clk) begin
    if (pm_en) pm_rdata <= mem_word(pm_addr);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_ptr(logic [7:0] v);
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_we = 1'b0;
    check("R2 pointer readback", 32'(ptr_rdata), 32'(v));
    cur_ptr = v;
  endtask

  task automatic do_read(logic m, logic [10:0] pcv, logic [7:0] dst, bit hold_start);
    logic [10:0] exp_addr;
    logic [13:0] w;
    exp_addr = m ? {3'b111, cur_ptr} : {pcv[10:8], cur_ptr};
    w = mem_word(exp_addr);
    @(negedge clk);
    start = 1'b1; mode = m; pc = pcv; dst_addr = dst;
    @(negedge clk);
    // fetch cycle
    check(m ? "R4 last-page addr" : "R3 current-page addr", 32'(pm_addr), 32'(exp_addr));
    check("R7 fetch cycle pm_en/busy/done", {pm_en, busy, done}, 3'b110);
    check("R9 hi held before overwrite", 32'(hi_rdata), 32'(last_hi));
    if (hold_start) begin
      mode = ~m; pc = ~pcv; dst_addr = ~dst;
    end else start = 1'b0;
    @(negedge clk);
    // write-back cycle
    check("R7 load cycle done/busy", {done, busy, pm_en}, 3'b110);
    check("R5 dm_we", 32'(dm_we), 32'd1);
    check("R5 dm_addr", 32'(dm_addr), 32'(dst));
    check("R5 dm_wdata", 32'(dm_wdata), 32'(w[7:0]));
    @(negedge clk);
    start = 1'b0;
    if (hold_start) check("R8 start while busy ignored", 32'(busy), 32'd0);
    check("R7 idle after two cycles", {busy, done, dm_we, pm_en}, 4'b0000);
    check("R6 hi register", 32'(hi_rdata), {24'd0, 2'b00, w[13:8]});
    last_hi = {2'b00, w[13:8]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ptr_we = 0; ptr_wdata = 0; start = 0; mode = 0;
    pc = 0; dst_addr = 0; pm_rdata = 0; cur_ptr = 0; last_hi = 0;
    repeat (3) @(negedge clk);
    check("R1 reset busy/done/pm_en/dm_we", {busy, done, pm_en, dm_we}, 4'b0000);
    check("R1 reset ptr", 32'(ptr_rdata), 32'd0);
    check("R1 reset hi", 32'(hi_rdata), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release ptr/hi", {ptr_rdata, hi_rdata}, 16'h0000);
    check("R1 after release busy", 32'(busy), 32'd0);

    // directed corners
    do_read(1'b0, 11'h000, 8'h10, 1'b0);
    write_ptr(8'hFF);
    do_read(1'b0, 11'h7FF, 8'hFF, 1'b0);
    do_read(1'b1, 11'h000, 8'h00, 1'b0);
    write_ptr(8'h00);
    do_read(1'b1, 11'h3AB, 8'h5A, 1'b1);
    do_read(1'b0, 11'h5C0, 8'hA5, 1'b1);

    // R2: start together with pointer write uses old pointer
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = 8'h77; start = 1'b1; mode = 1'b0; pc = 11'h200;
    @(negedge clk);
    ptr_we = 1'b0; start = 1'b0;
    check("R2 start with write uses old pointer", 32'(pm_addr), 32'(11'h200));
    repeat (2) @(negedge clk);
    last_hi = {2'b00, mem_word(11'h200) >> 8};
    check("R2 new pointer after write", 32'(ptr_rdata), 32'h77);
    cur_ptr = 8'h77;

    // R2: no write, pointer holds across reads
    do_read(1'b1, 11'h123, 8'h01, 1'b0);
    check("R2 pointer held", 32'(ptr_rdata), 32'h77);

    // random mix
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 2) == 0) write_ptr(8'($urandom));
      do_read(1'($urandom), 11'($urandom), 8'($urandom), ($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule